// File: doc/BRIEF.md
# Seeded Two-Bit Branch Direction Predictor

This block is a direct-mapped table of 2-bit saturating counters that predicts the direction of conditional branches. A lookup presents a branch address and a flag that says whether its target lies behind it. The block returns a taken or not-taken guess at once, with no clock edge in between, together with the counter value behind the guess. An update presents the address of a resolved branch and its real outcome. The addressed counter moves one step toward that outcome on the next clock edge.

Each entry also keeps a "seen" bit, which reset clears. When seeding is switched on and a backward branch performs a lookup on an entry that nothing has touched since reset, the entry starts at strongly taken instead of strongly not taken. The guess returned for that same lookup already reflects this. A loop-closing branch is then predicted correctly from its first iteration. With seeding switched off, the table behaves as a plain 2-bit predictor.

The table has no tags. Branches whose addresses share the index bits share one counter, and nothing detects this.

Top module: `bht_seeded`

## Requirements
- R1: After reset every entry reads counter 00 and predicts not taken, as long as no seeding applies.
- R2: Counter codes 00 and 01 predict not taken, and codes 10 and 11 predict taken. The guess is the upper counter bit.
- R3: An update with outcome taken adds one to the counter and holds it at 11 once it reaches 11.
- R4: An update with outcome not taken subtracts one from the counter and holds it at 00 once it reaches 00.
- R5: Seeding may be on and a valid lookup with the backward flag set may reach an unseen entry. In that case the lookup already reports counter 11 and taken, and the entry stores 11 at the next edge.
- R6: A valid lookup with the backward flag clear that reaches an unseen entry reports 00, leaves the counter at 00 and marks the entry seen.
- R7: Seeding acts only on an unseen entry. A backward lookup never reseeds an entry that a lookup or an update has already touched since reset.
- R8: With seeding off, a backward lookup on an unseen entry reports 00, and the entry stays at 00 and is marked seen.
- R9: The index is branch address bits [7:2], which gives 64 entries. Addresses that differ only outside these bits read and train the same counter.
- R10: A seeding lookup and an update may reach the same unseen entry in one cycle. The update is then applied to the seeded value, so a not-taken outcome leaves 10.
- R11: A branch run through 20 iterations (taken 19 times, then not taken), with a lookup and then an update each iteration, gets 17 correct guesses with seeding off and 19 with seeding on.
- R12: A lookup with its valid input low writes nothing, so an unseen entry stays unseen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_en | input | 1 | Turns backward-taken seeding on |
| lk_valid | input | 1 | Lookup present; allows the lookup to seed and mark its entry |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_backward | input | 1 | The looked-up branch jumps to a lower address |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | 2 | Counter value behind the prediction, seeding included |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The counters are driven with runs of updates that are all taken and then all not taken. These runs separate correct saturation at both ends from wrap-around and off-by-one stepping. First accesses are made with backward and forward lookups and with seeding on and off. They show whether the seed depends on both the enable and the direction, and whether the "seen" bit blocks any later reseeding. A lookup with its valid input low shows whether a mere address presentation changes state. A same-cycle collision of a lookup and an update shows which of the two writes wins. Aliased addresses and the 20-iteration loop, run once with seeding off and once with it on, confirm the indexing and the expected 17 and 19 correct guesses.

// File: rtl/bht_seeded.sv
module bht_seeded #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_en,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_backward,
  output logic            lk_taken,
  output logic [1:0]      lk_ctr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0][1:0] ctr;
  logic [N-1:0]      seen;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [1:0]       seed_val, base, nxt;
  logic             lk_fresh, same;

  assign lk_idx   = lk_pc[IDX_LSB +: IDX_W];
  assign up_idx   = upd_pc[IDX_LSB +: IDX_W];
  assign lk_fresh = !seen[lk_idx];
  assign seed_val = (seed_en && lk_backward) ? 2'b11 : 2'b00;
  assign lk_ctr   = lk_fresh ? seed_val : ctr[lk_idx];
  assign lk_taken = lk_ctr[1];

  // an update colliding with a first lookup starts from the seeded value
  assign same = lk_valid && (lk_idx == up_idx);
  assign base = same ? lk_ctr : ctr[up_idx];

  always_comb begin
    if (upd_taken) nxt = (base == 2'b11) ? base : base + 2'd1;
    else           nxt = (base == 2'b00) ? base : base - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr  <= '0;
      seen <= '0;
    end else begin
      if (lk_valid && lk_fresh) begin
        ctr[lk_idx]  <= seed_val;
        seen[lk_idx] <= 1'b1;
      end
      if (upd_valid) begin
        ctr[up_idx]  <= nxt;
        seen[up_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bht_seeded_chk.sv
module bht_seeded_chk #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            seed_en,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_backward,
  input logic [1:0]      lk_ctr,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken
);
  logic hit;
  assign hit = lk_valid && upd_valid &&
               (lk_pc[IDX_LSB +: IDX_W] == upd_pc[IDX_LSB +: IDX_W]);

  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && upd_taken && lk_ctr != 2'b11) |=>
      (lk_pc != $past(lk_pc) || lk_ctr == $past(lk_ctr) + 2'd1));

  a_r3_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && upd_taken && lk_ctr == 2'b11) |=>
      (lk_pc != $past(lk_pc) || lk_ctr == 2'b11));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !upd_taken && lk_ctr != 2'b00) |=>
      (lk_pc != $past(lk_pc) || lk_ctr == $past(lk_ctr) - 2'd1));

  a_r4_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !upd_taken && lk_ctr == 2'b00) |=>
      (lk_pc != $past(lk_pc) || lk_ctr == 2'b00));

  a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && !upd_valid) |=>
      (lk_pc != $past(lk_pc) || seed_en != $past(seed_en) ||
       lk_backward != $past(lk_backward) || lk_ctr == $past(lk_ctr)));
endmodule

bind bht_seeded bht_seeded_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .lk_valid(lk_valid),
  .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_ctr(lk_ctr),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/tb_bht_seeded.sv
module tb_bht_seeded;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_en = 1'b0, lk_valid = 1'b0, lk_backward = 1'b0;
  logic [31:0] lk_pc = '0, upd_pc = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic        lk_taken;
  logic [1:0]  lk_ctr;
  int vectors = 0, miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  bht_seeded dut (
    .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .lk_valid(lk_valid),
    .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(lk_taken),
    .lk_ctr(lk_ctr), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    lk_valid = 0; upd_valid = 0; seed_en = 0; lk_backward = 0;
    rst_n = 0; #3; rst_n = 1; #1;
  endtask

  // passive view of an entry: lk_valid low, so nothing is written
  task automatic peek(input logic [31:0] pc, input logic se, input logic bw);
    lk_valid = 0; lk_pc = pc; seed_en = se; lk_backward = bw; #1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    upd_valid = 1; upd_pc = pc; upd_taken = t; tick(); upd_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 64; i++) begin
      peek(32'(i) << 2, 0, 1);
      check("R1 ctr", lk_ctr, 0);
      check("R1 pred", lk_taken, 0);
    end
  endtask

  task automatic t_saturate();
    int exp_up[4] = '{1, 2, 3, 3};
    int exp_dn[4] = '{2, 1, 0, 0};
    do_reset();
    for (int i = 0; i < 4; i++) begin
      upd(32'h40, 1); peek(32'h40, 0, 0);
      check("R3 ctr", lk_ctr, exp_up[i]);
      check("R2 pred", lk_taken, exp_up[i] >= 2);
    end
    for (int i = 0; i < 4; i++) begin
      upd(32'h40, 0); peek(32'h40, 0, 0);
      check("R4 ctr", lk_ctr, exp_dn[i]);
      check("R2 pred", lk_taken, exp_dn[i] >= 2);
    end
  endtask

  task automatic t_seed_backward();
    do_reset();
    lk_valid = 1; lk_pc = 32'h80; lk_backward = 1; seed_en = 1; #1;
    check("R5 ctr same cycle", lk_ctr, 3);
    check("R5 pred", lk_taken, 1);
    tick();
    peek(32'h80, 0, 1);
    check("R5 stored", lk_ctr, 3);
    upd(32'h80, 0); upd(32'h80, 0);
    peek(32'h80, 1, 1);
    check("R7 no reseed", lk_ctr, 1);
    lk_valid = 1; tick();
    peek(32'h80, 1, 1);
    check("R7 no reseed after lookup", lk_ctr, 1);
  endtask

  task automatic t_seed_forward();
    do_reset();
    lk_valid = 1; lk_pc = 32'hC0; lk_backward = 0; seed_en = 1; #1;
    check("R6 ctr", lk_ctr, 0);
    tick();
    peek(32'hC0, 1, 1);
    check("R6 marked seen", lk_ctr, 0);
  endtask

  task automatic t_seed_off();
    do_reset();
    lk_valid = 1; lk_pc = 32'h24; lk_backward = 1; seed_en = 0; #1;
    check("R8 ctr", lk_ctr, 0);
    tick();
    peek(32'h24, 1, 1);
    check("R8 marked seen", lk_ctr, 0);
  endtask

  task automatic t_idle_lookup();
    do_reset();
    peek(32'h30, 1, 1); tick();
    peek(32'h30, 0, 1);
    check("R12 still unseen", lk_ctr, 0);
    peek(32'h30, 1, 1);
    check("R12 still seedable", lk_ctr, 3);
  endtask

  task automatic t_alias();
    do_reset();
    upd(32'h104, 1); upd(32'h104, 1);
    peek(32'h1107, 0, 0);
    check("R9 alias shares", lk_ctr, 2);
    peek(32'h108, 0, 0);
    check("R9 neighbour untouched", lk_ctr, 0);
    upd(32'hFFFF0104, 0);
    peek(32'h104, 0, 0);
    check("R9 alias trains", lk_ctr, 1);
  endtask

  task automatic t_collide();
    do_reset();
    seed_en = 1; lk_valid = 1; lk_pc = 32'h50; lk_backward = 1;
    upd_valid = 1; upd_pc = 32'h50; upd_taken = 0;
    tick(); upd_valid = 0;
    peek(32'h50, 0, 0);
    check("R10 update over seed", lk_ctr, 2);
  endtask

  task automatic t_loop(input logic se, input int exp_ok);
    int ok = 0;
    logic act;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      act = (i < 19);
      lk_valid = 1; lk_pc = 32'h200; lk_backward = 1; seed_en = se; #1;
      if (lk_taken == act) ok++;
      tick(); lk_valid = 0;
      upd(32'h200, act);
    end
    check(se ? "R11 seeded loop" : "R11 plain loop", ok, exp_ok);
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_saturate();
    t_seed_backward();
    t_seed_forward();
    t_seed_off();
    t_idle_lookup();
    t_alias();
    t_collide();
    t_loop(0, 17);
    t_loop(1, 19);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule